// File: doc/BRIEF.md
# ADC Sample Sequencer Controller

This block sits between four independent sample sequencers and one shared analog converter. Each sequencer owns a short program of steps (8, 4, 4 and 1 steps for sequencers 0 to 3). Every step stores a 4-bit input selector and a 4-bit control nibble. A sequencer starts only while its enable bit is set, and only on the trigger source that its own 4-bit select names. Once started, it walks its steps from step 0 and asks the converter for one conversion per step. For each step it presents an input or pair code, a differential flag and a temperature-sensor flag.

The converter is modelled as a request/done handshake. `conv_req` stays high until `conv_done` is sampled high, and `conv_data` must be valid in that same cycle. Each 12-bit result goes into the result FIFO of the sequencer that produced it. The FIFO depth equals that sequencer's step count. Software pops a result through a single read port, and the result comes back zero-extended to 32 bits. When several sequencers are waiting at once, they are served one whole sequence at a time, lowest number first.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_req`, `step_done`, `ovf` and `unf` are all 0, and every bit of `fifo_empty` is 1.
- R2: With trigger select 0x0, a 1 on `sw_start[x]` starts sequencer x. A 0 on that bit does nothing, and `sw_start` does nothing for a sequencer whose select is not 0x0.
- R3: A sequencer whose `seq_en` bit is 0 ignores every trigger and issues no conversion.
- R4: The trigger select codes map as follows: 0x1 → `trig_ev[0]`, 0x2 → `trig_ev[1]`, 0x4 → `trig_ev[2]`, 0x5 → `trig_ev[3]`, 0x6..0x9 → `trig_ev[4]..trig_ev[7]`, and 0xF → restart continuously while enabled. Code 0x3 and all other codes never trigger. Event bits other than the selected one do not start the sequencer.
- R5: A started sequence issues one conversion per step, starting at step 0. It stops after the first step whose control bit 1 (end) is set, or after its last physical step. `conv_code` carries the step's selector nibble and stays stable while a request is waiting.
- R6: Control bit 0 of the step drives `conv_diff`, and the selector then holds a pair number. Control bit 3 drives `conv_temp`. When bit 3 is set, `conv_diff` is forced to 0.
- R7: When a step completes and its control bit 2 is set, `step_done[x]` pulses high for one cycle, in the cycle after the handshake. Several steps of one sequence may each pulse.
- R8: Results enter the producing sequencer's FIFO in conversion order. `rd_data` shows the head of FIFO `rd_seq` in bits 11:0, with bits 31:12 at zero. A cycle with `rd_en` high pops that head.
- R9: A result that arrives while its FIFO is full is dropped, and `ovf[x]` is set and stays set until reset. The stored results are kept.
- R10: A read of an empty FIFO returns 0 and sets the sticky flag `unf[x]`.
- R11: When several sequencers are pending, the lowest-numbered one runs its whole sequence first.
- R12: `busy` is 1 for every cycle in which a sequence is in progress, including every cycle that `conv_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one step entry |
| cfg_seq | input | 2 | Sequencer of the written step |
| cfg_step | input | 3 | Step index within that sequencer |
| cfg_chan | input | 4 | Input selector or pair number |
| cfg_ctl | input | 4 | Control nibble: bit0 differential, bit1 end, bit2 completion pulse, bit3 temperature sensor |
| seq_en | input | 4 | Enable bit of each sequencer |
| trig_sel | input | 16 | 4-bit trigger select of each sequencer; sequencer x uses bits 4x+3:4x |
| sw_start | input | 4 | Processor start pulses |
| trig_ev | input | 8 | Hardware trigger events |
| conv_req | output | 1 | Conversion request |
| conv_code | output | 4 | Input or pair code of the current step |
| conv_diff | output | 1 | Differential conversion |
| conv_temp | output | 1 | Convert the temperature sensor |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | 12 | Conversion result |
| rd_en | input | 1 | Pop the selected FIFO |
| rd_seq | input | 2 | FIFO being read |
| rd_data | output | 32 | Zero-extended head of the selected FIFO |
| fifo_empty | output | 4 | FIFO empty flags |
| step_done | output | 4 | One-cycle completion pulses |
| busy | output | 1 | Sequence in progress |
| ovf | output | 4 | Sticky overflow flags |
| unf | output | 4 | Sticky underflow flags |

## Verification
A wrong step pointer or base offset shows up on `conv_code` as soon as the request is issued, within two cycles of the trigger. A missed end detection shows up as extra requests right after the last expected handshake. A pending bit that is wrongly cleared or kept shows up as a missing or repeated sequence, or as the wrong order of first codes when all four sequencers start together. A broken FIFO pointer or count stays hidden until the results are popped. It then appears as results out of order, a wrong empty flag, or an overflow flag that is set early or never.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SEQ   = 4;
  localparam int SEQ_W     = $clog2(NUM_SEQ);
  localparam int MAX_STEPS = 8;
  localparam int STEP_W    = $clog2(MAX_STEPS);
  localparam int RES_W     = 12;
  localparam int RD_W      = 32;
  localparam int EV_W      = 8;
  localparam int unsigned SEQ_STEPS [NUM_SEQ] = '{8, 4, 4, 1};

  localparam logic [3:0] TRG_CPU    = 4'h0;
  localparam logic [3:0] TRG_CMP0   = 4'h1;
  localparam logic [3:0] TRG_CMP1   = 4'h2;
  localparam logic [3:0] TRG_PIN    = 4'h4;
  localparam logic [3:0] TRG_TMR    = 4'h5;
  localparam logic [3:0] TRG_PWM0   = 4'h6;
  localparam logic [3:0] TRG_PWM1   = 4'h7;
  localparam logic [3:0] TRG_PWM2   = 4'h8;
  localparam logic [3:0] TRG_PWM3   = 4'h9;
  localparam logic [3:0] TRG_ALWAYS = 4'hF;

  typedef struct packed {
    logic temp;
    logic ie;
    logic last;
    logic diff;
  } step_ctl_t;

  typedef struct packed {
    step_ctl_t  ctl;
    logic [3:0] chan;
  } step_t;

  // First table slot of sequencer s (steps are packed back to back).
  function automatic int step_base(input int s);
    int acc;
    acc = 0;
    for (int i = 0; i < NUM_SEQ; i++)
      if (i < s) acc += int'(SEQ_STEPS[i]);
    return acc;
  endfunction

  localparam int TOTAL_STEPS = step_base(NUM_SEQ);

  function automatic logic trig_hit(input logic [3:0] sel, input logic sw,
                                    input logic [EV_W-1:0] ev);
    case (sel)
      TRG_CPU:    return sw;
      TRG_CMP0:   return ev[0];
      TRG_CMP1:   return ev[1];
      TRG_PIN:    return ev[2];
      TRG_TMR:    return ev[3];
      TRG_PWM0:   return ev[4];
      TRG_PWM1:   return ev[5];
      TRG_PWM2:   return ev[6];
      TRG_PWM3:   return ev[7];
      TRG_ALWAYS: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  // Lowest-numbered pending sequencer wins.
  function automatic logic [SEQ_W-1:0] first_pending(input logic [NUM_SEQ-1:0] p);
    logic [SEQ_W-1:0] w;
    w = '0;
    for (int i = NUM_SEQ - 1; i >= 0; i--)
      if (p[i]) w = SEQ_W'(i);
    return w;
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic            en,
  input  logic [3:0]      sel,
  input  logic            sw,
  input  logic [EV_W-1:0] ev,
  output logic            hit
);
  assign hit = en && trig_hit(sel, sw, ev);
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEQ_W-1:0]     cfg_seq,
  input  logic [STEP_W-1:0]    cfg_step,
  input  logic [3:0]           cfg_chan,
  input  logic [3:0]           cfg_ctl,
  input  logic [NUM_SEQ-1:0]   seq_en,
  input  logic [4*NUM_SEQ-1:0] trig_sel,
  input  logic [NUM_SEQ-1:0]   sw_start,
  input  logic [EV_W-1:0]      trig_ev,
  output logic                 conv_req,
  output logic [3:0]           conv_code,
  output logic                 conv_diff,
  output logic                 conv_temp,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  input  logic                 rd_en,
  input  logic [SEQ_W-1:0]     rd_seq,
  output logic [RD_W-1:0]      rd_data,
  output logic [NUM_SEQ-1:0]   fifo_empty,
  output logic [NUM_SEQ-1:0]   step_done,
  output logic                 busy,
  output logic [NUM_SEQ-1:0]   ovf,
  output logic [NUM_SEQ-1:0]   unf
);
  localparam int IDX_W = $clog2(TOTAL_STEPS);

  step_t               tbl [TOTAL_STEPS];
  logic [NUM_SEQ-1:0]  hit, pend, push, pop, grant_oh;
  logic                running;
  logic [SEQ_W-1:0]    cur_seq, grant;
  logic [STEP_W-1:0]   cur_step;
  logic [IDX_W-1:0]    cur_idx, cfg_idx;
  step_t               cur;
  logic [RES_W-1:0]    head [NUM_SEQ];
  logic                cfg_ok;

  // Named internal events.
  logic conv_fire, step_last, seq_start;

  assign cfg_ok  = 32'(cfg_step) < SEQ_STEPS[cfg_seq];
  assign cfg_idx = IDX_W'(step_base(int'(cfg_seq)) + int'(cfg_step));
  assign cur_idx = IDX_W'(step_base(int'(cur_seq)) + int'(cur_step));
  assign cur     = tbl[cur_idx];

  assign conv_fire = running && conv_done;
  assign step_last = cur.ctl.last || (32'(cur_step) == SEQ_STEPS[cur_seq] - 1);
  assign seq_start = !running && (|pend);
  assign grant     = first_pending(pend);
  assign grant_oh  = seq_start ? (NUM_SEQ'(1) << grant) : '0;

  assign conv_req  = running;
  assign conv_code = cur.chan;
  assign conv_temp = cur.ctl.temp;
  assign conv_diff = cur.ctl.diff && !cur.ctl.temp;
  assign busy      = running;
  assign rd_data   = RD_W'(head[rd_seq]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL_STEPS; i++) tbl[i] <= '0;
    end else if (cfg_we && cfg_ok) begin
      tbl[cfg_idx] <= step_t'({cfg_ctl, cfg_chan});
    end
  end

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    adc_trig_sel u_trig (
      .en (seq_en[g]),
      .sel(trig_sel[4*g +: 4]),
      .sw (sw_start[g]),
      .ev (trig_ev),
      .hit(hit[g])
    );

    assign push[g] = conv_fire && (cur_seq == SEQ_W'(g));
    assign pop[g]  = rd_en && (rd_seq == SEQ_W'(g));

    adc_res_fifo #(.DEPTH(int'(SEQ_STEPS[g])), .W(RES_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push[g]),
      .pop  (pop[g]),
      .din  (conv_data),
      .head (head[g]),
      .empty(fifo_empty[g]),
      .ovf  (ovf[g]),
      .unf  (unf[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= ((pend & ~grant_oh) | hit) & seq_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cur_seq   <= '0;
      cur_step  <= '0;
      step_done <= '0;
    end else begin
      step_done <= '0;
      if (seq_start) begin
        running  <= 1'b1;
        cur_seq  <= grant;
        cur_step <= '0;
      end else if (conv_fire) begin
        if (cur.ctl.ie) step_done[cur_seq] <= 1'b1;
        if (step_last) running <= 1'b0;
        else           cur_step <= cur_step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               conv_req,
  input logic               conv_done,
  input logic [3:0]         conv_code,
  input logic               conv_temp,
  input logic               busy,
  input logic [NUM_SEQ-1:0] step_done,
  input logic [NUM_SEQ-1:0] ovf,
  input logic [NUM_SEQ-1:0] unf,
  input logic               rd_en,
  input logic [SEQ_W-1:0]   rd_seq,
  input logic [NUM_SEQ-1:0] fifo_empty
);
  assert_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_code) && $stable(conv_temp)));

  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_done));

  assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|step_done) |-> $past(conv_req && conv_done));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf & $past(ovf)) == $past(ovf));

  assert_unf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty[rd_seq]) |=> unf[$past(rd_seq)]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_req  (conv_req),
  .conv_done (conv_done),
  .conv_code (conv_code),
  .conv_temp (conv_temp),
  .busy      (busy),
  .step_done (step_done),
  .ovf       (ovf),
  .unf       (unf),
  .rd_en     (rd_en),
  .rd_seq    (rd_seq),
  .fifo_empty(fifo_empty)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_seq = 0;
  logic [2:0]  cfg_step = 0;
  logic [3:0]  cfg_chan = 0, cfg_ctl = 0;
  logic [3:0]  seq_en = 0;
  logic [15:0] trig_sel = 0;
  logic [3:0]  sw_start = 0;
  logic [7:0]  trig_ev = 0;
  logic        conv_req, conv_diff, conv_temp;
  logic [3:0]  conv_code;
  logic        conv_done = 0;
  logic [11:0] conv_data = 0;
  logic        rd_en = 0;
  logic [1:0]  rd_seq = 0;
  logic [31:0] rd_data;
  logic [3:0]  fifo_empty, step_done, ovf, unf;
  logic        busy;

  int checks = 0, failures = 0, n_conv = 0;
  int lg_code [256], lg_diff [256], lg_temp [256];
  int sd_cnt [4] = '{0, 0, 0, 0};
  bit finished = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Converter model: answers one cycle after each request; data tags the conversion.
  always @(negedge clk) begin
    if (!rst_n) conv_done = 0;
    else if (conv_req && !conv_done) begin
      lg_code[n_conv % 256] = int'(conv_code);
      lg_diff[n_conv % 256] = int'(conv_diff);
      lg_temp[n_conv % 256] = int'(conv_temp);
      conv_data = {4'(n_conv), conv_temp, conv_diff, 2'b00, conv_code};
      conv_done = 1;
      n_conv++;
      check(busy == 1'b1, "R12", "busy during request", int'(busy), 1);
    end else conv_done = 0;
  end

  always @(negedge clk)
    for (int i = 0; i < 4; i++) if (step_done[i]) sd_cnt[i]++;

  task automatic wr_step(input int s, input int st, input int ch, input int ctl);
    @(negedge clk);
    cfg_we = 1; cfg_seq = 2'(s); cfg_step = 3'(st); cfg_chan = 4'(ch); cfg_ctl = 4'(ctl);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_sel(input int s, input int v);
    trig_sel[4*s +: 4] = 4'(v);
  endtask

  task automatic pulse_sw(input logic [3:0] m);
    @(negedge clk); sw_start = m;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic pulse_ev(input logic [7:0] m);
    @(negedge clk); trig_ev = m;
    @(negedge clk); trig_ev = 0;
  endtask

  task automatic wait_idle();
    int q;
    q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic rd(input int s, output logic [31:0] d);
    @(negedge clk); rd_seq = 2'(s); rd_en = 1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic drain(input int s);
    logic [31:0] d;
    while (!fifo_empty[s]) rd(s, d);
  endtask

  task automatic t_reset();
    check(busy == 0, "R1", "busy", int'(busy), 0);
    check(conv_req == 0, "R1", "conv_req", int'(conv_req), 0);
    check(fifo_empty == 4'hF, "R1", "fifo_empty", int'(fifo_empty), 15);
    check(ovf == 0 && unf == 0 && step_done == 0, "R1", "flags", int'({ovf, unf, step_done}), 0);
  endtask

  task automatic t_cpu_start();
    int n0, s0;
    logic [31:0] d;
    n0 = n_conv; s0 = sd_cnt[0];
    seq_en[0] = 1; set_sel(0, 0);
    pulse_sw(4'b0001);
    @(negedge clk);
    check(busy == 1, "R12", "busy after start", int'(busy), 1);
    wait_idle();
    check(n_conv - n0 == 3, "R5", "steps up to end bit", n_conv - n0, 3);
    for (int k = 0; k < 3; k++) begin
      check(lg_code[n0 + k] == k, "R5", "step code", lg_code[n0 + k], k);
      check(lg_diff[n0 + k] == (k == 1), "R6", "diff flag", lg_diff[n0 + k], int'(k == 1));
    end
    check(sd_cnt[0] - s0 == 2, "R7", "completion pulses", sd_cnt[0] - s0, 2);
    for (int k = 0; k < 3; k++) begin
      rd(0, d);
      check(d[3:0] == 4'(k) && d[11:8] == 4'(n0 + k), "R8", "fifo order", int'(d[11:0]), k);
      check(d[31:12] == 0, "R8", "upper bits zero", int'(d[31:12]), 0);
    end
    check(fifo_empty[0] == 1, "R8", "empty after reads", int'(fifo_empty[0]), 1);
    seq_en[0] = 0;
  endtask

  task automatic t_ignored();
    int n0;
    n0 = n_conv;
    seq_en[1] = 0; set_sel(1, 0);
    pulse_sw(4'b0010); wait_idle();
    check(n_conv == n0, "R3", "disabled sequencer started", n_conv - n0, 0);
    seq_en[1] = 1; set_sel(1, 5);
    pulse_sw(4'b0010); pulse_sw(4'b0000); wait_idle();
    check(n_conv == n0, "R2", "sw start with timer select", n_conv - n0, 0);
    pulse_ev(8'hF7); wait_idle();
    check(n_conv == n0, "R4", "non-selected events", n_conv - n0, 0);
    pulse_ev(8'h08); wait_idle();
    check(n_conv - n0 == 4, "R5", "runs to last physical step", n_conv - n0, 4);
    for (int k = 0; k < 4; k++)
      check(lg_code[n0 + k] == 4 + k, "R5", "step code", lg_code[n0 + k], 4 + k);
    drain(1);
    seq_en[1] = 0;
  endtask

  task automatic t_events();
    int codes [8] = '{1, 2, 4, 5, 6, 7, 8, 9};
    int n0;
    seq_en[3] = 1;
    for (int i = 0; i < 8; i++) begin
      set_sel(3, codes[i]);
      n0 = n_conv;
      pulse_ev(~(8'h01 << i)); wait_idle();
      check(n_conv == n0, "R4", "other events ignored", n_conv - n0, 0);
      pulse_ev(8'h01 << i); wait_idle();
      check(n_conv - n0 == 1 && lg_code[n0] == 11, "R4", "selected event starts", n_conv - n0, 1);
      drain(3);
    end
    set_sel(3, 3);
    n0 = n_conv;
    pulse_ev(8'hFF); pulse_sw(4'b1000); wait_idle();
    check(n_conv == n0, "R4", "reserved select", n_conv - n0, 0);
    seq_en[3] = 0;
  endtask

  task automatic t_temp();
    int n0;
    n0 = n_conv;
    seq_en[2] = 1; set_sel(2, 0);
    pulse_sw(4'b0100); wait_idle();
    check(n_conv - n0 == 2, "R5", "two steps", n_conv - n0, 2);
    check(lg_temp[n0] == 1 && lg_diff[n0] == 0, "R6", "sensor forces single-ended",
          lg_diff[n0], 0);
    check(lg_temp[n0 + 1] == 0 && lg_diff[n0 + 1] == 1 && lg_code[n0 + 1] == 5, "R6",
          "pair step", lg_code[n0 + 1], 5);
    drain(2);
    seq_en[2] = 0;
  endtask

  task automatic t_priority();
    int n0;
    n0 = n_conv;
    seq_en = 4'hF; trig_sel = 16'h0000;
    pulse_sw(4'hF); wait_idle();
    check(n_conv - n0 == 10, "R11", "all sequences ran", n_conv - n0, 10);
    check(lg_code[n0] == 0, "R11", "sequencer 0 first", lg_code[n0], 0);
    check(lg_code[n0 + 3] == 4, "R11", "sequencer 1 second", lg_code[n0 + 3], 4);
    check(lg_code[n0 + 7] == 9, "R11", "sequencer 2 third", lg_code[n0 + 7], 9);
    check(lg_code[n0 + 9] == 11, "R11", "sequencer 3 last", lg_code[n0 + 9], 11);
    for (int s = 0; s < 4; s++) drain(s);
    seq_en = 0;
  endtask

  task automatic t_overflow();
    int n0;
    logic [31:0] d;
    n0 = n_conv;
    seq_en[3] = 1; set_sel(3, 0);
    check(ovf[3] == 0, "R9", "ovf before", int'(ovf[3]), 0);
    pulse_sw(4'b1000); wait_idle();
    pulse_sw(4'b1000); wait_idle();
    check(ovf[3] == 1, "R9", "ovf after second push", int'(ovf[3]), 1);
    rd(3, d);
    check(d[11:8] == 4'(n0), "R9", "first result kept", int'(d[11:8]), n0 % 16);
    check(fifo_empty[3] == 1 && ovf[3] == 1, "R9", "dropped result gone, flag held",
          int'(fifo_empty[3]), 1);
    seq_en[3] = 0;
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    check(unf[1] == 0, "R10", "unf before", int'(unf[1]), 0);
    rd(1, d);
    check(d == 0, "R10", "empty read data", int'(d), 0);
    @(negedge clk);
    check(unf[1] == 1, "R10", "unf set", int'(unf[1]), 1);
  endtask

  task automatic t_continuous();
    int n0;
    n0 = n_conv;
    set_sel(3, 15); seq_en[3] = 1;
    repeat (20) @(negedge clk);
    seq_en[3] = 0;
    wait_idle();
    check(n_conv - n0 >= 4, "R4", "continuous restarts", n_conv - n0, 4);
    drain(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    wr_step(0, 0, 0, 4'b0100);
    wr_step(0, 1, 1, 4'b0001);
    wr_step(0, 2, 2, 4'b0110);
    for (int k = 0; k < 4; k++) wr_step(1, k, 4 + k, 0);
    wr_step(2, 0, 9, 4'b1001);
    wr_step(2, 1, 5, 4'b0011);
    wr_step(3, 0, 11, 4'b0110);
    t_cpu_start();
    t_ignored();
    t_events();
    t_temp();
    t_priority();
    t_overflow();
    t_underflow();
    t_continuous();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule